// File: doc/BRIEF.md
# IPv4 Fast-Path Forward/Punt Stage

This stage sits after header parsing and table lookup in a four-port router. For every received frame it gets the EtherType, the destination MAC, the 20-byte IPv4 header as one vector, and the results of the route and ARP lookups. From these it makes one decision: the hardware forwards the packet, or the packet leaves the fast path. A forwarded packet gets a TTL one lower, a corrected header checksum, the next-hop MAC as its destination MAC, and a one-hot egress vector naming one MAC port.

Any other packet keeps its bytes exactly as they arrived. The elaboration-time parameter `PUNT_TO_CPU` sets what happens to it. With the parameter at 0, the egress vector is all zero and the packet is dropped. With the parameter at 1, the vector points at the CPU queue paired with the ingress port. Packets that software injects bypass every check and leave on the MAC port paired with the queue they came from, with nothing changed. A small table, written by software, holds the router's own IPv4 addresses. Traffic addressed to any of them is never forwarded.

The egress vector has two bits per port. Bit 2p selects MAC port p and bit 2p+1 selects CPU queue p. The decision and the rewritten fields are registered and appear one clock after `hdr_valid_i`.

Top module: `fp_hdr_proc`

## Requirements
- R1: Forwarding is possible only if all four header checks pass. The EtherType must be 0x0800. The version nibble (header bits 159:156) must be 4. The header-length nibble (bits 155:152) must be 5. The one's-complement sum of the ten 16-bit header words, with end-around carry, must equal 0xFFFF. Any other EtherType, including ARP (0x0806), or any failed check means the packet is not forwarded.
- R2: A packet arriving with TTL (header bits 95:88) equal to 0 or 1 is not forwarded. A forwarded packet leaves with TTL one lower than it arrived.
- R3: The checksum of a forwarded packet (header bits 79:64) is the incoming value plus 0x0100, with the carry added back in, so the rewritten header verifies again.
- R4: The local-address table has NUM_LOCAL entries. Each entry holds a 32-bit address and an enable bit. A write to an index is visible on the read port from the next cycle. Reset clears every enable bit.
- R5: If the destination address (header bits 31:0) equals an enabled table entry, the packet is not forwarded. Disabled entries never match.
- R6: A route-lookup miss or an ARP-lookup miss means the packet is not forwarded.
- R7: A forwarded packet sets only bit 2*route_port_i of the egress vector, and its output destination MAC equals arp_mac_i.
- R8: With PUNT_TO_CPU=0, a packet that is not forwarded gets an all-zero egress vector.
- R9: With PUNT_TO_CPU=1, a packet that is not forwarded sets only bit 2*ingress_i+1.
- R10: For a packet that is not forwarded, the output TTL, checksum and destination MAC equal the input values.
- R11: A packet with from_cpu_i set sets only bit 2*ingress_i, whatever its header holds, and leaves with TTL, checksum and MAC unchanged.
- R12: Outputs are valid exactly one cycle after hdr_valid_i. When out_valid_o is low, the egress vector is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header and lookup inputs valid this cycle |
| from_cpu_i | input | 1 | Packet was injected by software |
| ingress_i | input | 2 | Ingress port index |
| eth_type_i | input | 16 | EtherType |
| eth_dmac_i | input | 48 | Received destination MAC |
| ip_hdr_i | input | 160 | IPv4 header, first byte in bits 159:152 |
| route_hit_i | input | 1 | Route lookup found an entry |
| route_port_i | input | 2 | Egress port from route lookup |
| arp_hit_i | input | 1 | ARP lookup found an entry |
| arp_mac_i | input | 48 | Next-hop MAC |
| tbl_we_i | input | 1 | Local-table write strobe |
| tbl_idx_i | input | 2 | Local-table index for write and read |
| tbl_wr_addr_i | input | 32 | Address to write |
| tbl_wr_en_i | input | 1 | Enable bit to write |
| tbl_rd_addr_o | output | 32 | Address stored at tbl_idx_i |
| tbl_rd_en_o | output | 1 | Enable bit stored at tbl_idx_i |
| out_valid_o | output | 1 | Decision valid |
| out_fwd_o | output | 1 | Packet rewritten and forwarded |
| out_ports_o | output | 8 | Egress vector, MAC p at bit 2p, CPU p at bit 2p+1 |
| out_dmac_o | output | 48 | Outgoing destination MAC |
| out_ttl_o | output | 8 | Outgoing TTL |
| out_csum_o | output | 16 | Outgoing header checksum |

## Verification
The bench probes the TTL boundary from both sides. A TTL of 2 must be forwarded as 1, and TTLs of 1 and 0 must be punted. An off-by-one comparison would forward dead packets or drop live ones. The bench recomputes every rewritten checksum from scratch, which catches an update that adds 1 where 0x0100 is needed or loses the end-around carry. It also runs single-field corruptions (ARP EtherType, wrong version, header with options, one flipped checksum bit) and lookup misses. A missing check would forward those packets. The local table is tested by writing, reading back, matching and then disabling an entry, and a software-injected packet with TTL 0 must still leave untouched. A second instance built for CPU punting runs the same packets in parallel, so a wrong punt bit or a rewritten punted packet is visible.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int unsigned HDR_W   = 160;
  localparam int unsigned MAC_W   = 48;
  localparam int unsigned IP_W    = 32;
  localparam int unsigned WORDS   = HDR_W / 16;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [3:0]  IP_VER     = 4'd4;
  localparam logic [3:0]  IHL_PLAIN  = 4'd5;

  // header field positions, first byte at the top
  localparam int unsigned VER_LSB  = 156;
  localparam int unsigned IHL_LSB  = 152;
  localparam int unsigned TTL_LSB  = 88;
  localparam int unsigned CSUM_LSB = 64;
  localparam int unsigned DST_LSB  = 0;
endpackage

// File: rtl/fp_hdr_check.sv
module fp_hdr_check
  import fp_pkg::*;
(
  input  logic [15:0]      eth_type_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             hdr_ok_o,
  output logic             ttl_live_o
);
  logic [19:0] acc;
  logic [16:0] fold1;
  logic [16:0] fold2;
  logic        csum_ok;
  logic [3:0]  ver, ihl;
  logic [7:0]  ttl;

  assign ver = hdr_i[VER_LSB +: 4];
  assign ihl = hdr_i[IHL_LSB +: 4];
  assign ttl = hdr_i[TTL_LSB +: 8];

  always_comb begin
    acc = '0;
    for (int i = 0; i < WORDS; i++) acc = acc + {4'b0, hdr_i[16*i +: 16]};
    fold1 = {1'b0, acc[15:0]} + {13'b0, acc[19:16]};
    fold2 = {1'b0, fold1[15:0]} + {16'b0, fold1[16]};
  end

  assign csum_ok    = (fold2[15:0] == 16'hFFFF);
  assign hdr_ok_o   = (eth_type_i == ETYPE_IPV4) && (ver == IP_VER) &&
                      (ihl == IHL_PLAIN) && csum_ok;
  assign ttl_live_o = (ttl > 8'd1);
endmodule

// File: rtl/fp_csum_fix.sv
module fp_csum_fix (
  input  logic [15:0] csum_i,
  output logic [15:0] csum_o
);
  // TTL sits in the high byte of its word: -1 in TTL is +0x0100 in the checksum
  logic [16:0] sum;
  assign sum    = {1'b0, csum_i} + 17'h00100;
  assign csum_o = sum[15:0] + {15'b0, sum[16]};
endmodule

// File: rtl/fp_local_tbl.sv
module fp_local_tbl
  import fp_pkg::*;
#(
  parameter int unsigned NUM_LOCAL = 4,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCAL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IP_W-1:0] wr_addr_i,
  input  logic            wr_en_i,
  output logic [IP_W-1:0] rd_addr_o,
  output logic            rd_en_o,
  input  logic [IP_W-1:0] key_i,
  output logic            hit_o
);
  logic [IP_W-1:0]      addr_q [NUM_LOCAL];
  logic [NUM_LOCAL-1:0] en_q;
  logic [NUM_LOCAL-1:0] match;

  for (genvar g = 0; g < NUM_LOCAL; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        en_q[g]   <= 1'b0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        addr_q[g] <= wr_addr_i;
        en_q[g]   <= wr_en_i;
      end
    end
    assign match[g] = en_q[g] && (addr_q[g] == key_i);
  end

  assign hit_o     = |match;
  assign rd_addr_o = addr_q[idx_i];
  assign rd_en_o   = en_q[idx_i];

  p_wr_visible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (idx_i != $past(idx_i)) ||
             (rd_addr_o == $past(wr_addr_i) && rd_en_o == $past(wr_en_i)));

  p_off_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !hit_o);
endmodule

// File: rtl/fp_hdr_proc.sv
module fp_hdr_proc
  import fp_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned NUM_LOCAL   = 4,
  parameter bit          PUNT_TO_CPU = 1'b0,
  parameter int unsigned PORT_W      = $clog2(NUM_PORTS),
  parameter int unsigned LIDX_W      = $clog2(NUM_LOCAL),
  parameter int unsigned VEC_W       = 2 * NUM_PORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic              from_cpu_i,
  input  logic [PORT_W-1:0] ingress_i,
  input  logic [15:0]       eth_type_i,
  input  logic [MAC_W-1:0]  eth_dmac_i,
  input  logic [HDR_W-1:0]  ip_hdr_i,
  input  logic              route_hit_i,
  input  logic [PORT_W-1:0] route_port_i,
  input  logic              arp_hit_i,
  input  logic [MAC_W-1:0]  arp_mac_i,
  input  logic              tbl_we_i,
  input  logic [LIDX_W-1:0] tbl_idx_i,
  input  logic [IP_W-1:0]   tbl_wr_addr_i,
  input  logic              tbl_wr_en_i,
  output logic [IP_W-1:0]   tbl_rd_addr_o,
  output logic              tbl_rd_en_o,
  output logic              out_valid_o,
  output logic              out_fwd_o,
  output logic [VEC_W-1:0]  out_ports_o,
  output logic [MAC_W-1:0]  out_dmac_o,
  output logic [7:0]        out_ttl_o,
  output logic [15:0]       out_csum_o
);
  logic       hdr_ok, ttl_live, local_hit, fwd_ok;
  logic [7:0] ttl_in;
  logic [15:0] csum_in, csum_new;
  logic [VEC_W-1:0] fwd_vec, cpu_in_vec, punt_vec, nxt_ports;

  assign ttl_in  = ip_hdr_i[TTL_LSB +: 8];
  assign csum_in = ip_hdr_i[CSUM_LSB +: 16];

  fp_hdr_check i_chk (
    .eth_type_i (eth_type_i),
    .hdr_i      (ip_hdr_i),
    .hdr_ok_o   (hdr_ok),
    .ttl_live_o (ttl_live)
  );

  fp_csum_fix i_fix (
    .csum_i (csum_in),
    .csum_o (csum_new)
  );

  fp_local_tbl #(.NUM_LOCAL(NUM_LOCAL), .IDX_W(LIDX_W)) i_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .idx_i     (tbl_idx_i),
    .wr_addr_i (tbl_wr_addr_i),
    .wr_en_i   (tbl_wr_en_i),
    .rd_addr_o (tbl_rd_addr_o),
    .rd_en_o   (tbl_rd_en_o),
    .key_i     (ip_hdr_i[DST_LSB +: IP_W]),
    .hit_o     (local_hit)
  );

  assign fwd_ok = !from_cpu_i && hdr_ok && ttl_live && !local_hit &&
                  route_hit_i && arp_hit_i;

  assign fwd_vec    = VEC_W'(1) << {route_port_i, 1'b0};
  assign cpu_in_vec = VEC_W'(1) << {ingress_i, 1'b0};

  if (PUNT_TO_CPU) begin : g_punt_cpu
    assign punt_vec = VEC_W'(1) << {ingress_i, 1'b1};
  end else begin : g_punt_drop
    assign punt_vec = '0;
  end

  always_comb begin
    if (!hdr_valid_i)    nxt_ports = '0;
    else if (from_cpu_i) nxt_ports = cpu_in_vec;
    else if (fwd_ok)     nxt_ports = fwd_vec;
    else                 nxt_ports = punt_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_fwd_o   <= 1'b0;
      out_ports_o <= '0;
      out_dmac_o  <= '0;
      out_ttl_o   <= '0;
      out_csum_o  <= '0;
    end else begin
      out_valid_o <= hdr_valid_i;
      out_fwd_o   <= hdr_valid_i && fwd_ok;
      out_ports_o <= nxt_ports;
      if (hdr_valid_i) begin
        out_dmac_o <= fwd_ok ? arp_mac_i       : eth_dmac_i;
        out_ttl_o  <= fwd_ok ? ttl_in - 8'd1   : ttl_in;
        out_csum_o <= fwd_ok ? csum_new        : csum_in;
      end
    end
  end

  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_ports_o));

  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_ports_o == '0) && !out_fwd_o);

  p_fwd_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fwd_o |-> (out_ttl_o != 8'd0));

  p_ttl_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> !out_fwd_o || (out_ttl_o == $past(ttl_in) - 8'd1));

  p_miss_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !route_hit_i) |=>
      !out_fwd_o && out_ttl_o == $past(ttl_in) && out_csum_o == $past(csum_in));

  p_cpu_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && from_cpu_i) |=> !out_fwd_o && $countones(out_ports_o) == 1);
endmodule

// File: tb/test_fp_hdr_proc.sv
module test_fp_hdr_proc;
  localparam int unsigned VEC_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hdr_valid_i = 0, from_cpu_i = 0, route_hit_i = 0, arp_hit_i = 0;
  logic [1:0] ingress_i = 0, route_port_i = 0, tbl_idx_i = 0;
  logic [15:0] eth_type_i = 0;
  logic [47:0] eth_dmac_i = 0, arp_mac_i = 0;
  logic [159:0] ip_hdr_i = 0;
  logic tbl_we_i = 0, tbl_wr_en_i = 0;
  logic [31:0] tbl_wr_addr_i = 0;

  logic [31:0] rd_addr_d, rd_addr_c;
  logic rd_en_d, rd_en_c;
  logic val_d, val_c, fwd_d, fwd_c;
  logic [VEC_W-1:0] ports_d, ports_c;
  logic [47:0] dmac_d, dmac_c;
  logic [7:0] ttl_d, ttl_c;
  logic [15:0] csum_d, csum_c;

  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  fp_hdr_proc i_fp_hdr_proc (
    .clk_i, .rst_ni, .hdr_valid_i, .from_cpu_i, .ingress_i, .eth_type_i,
    .eth_dmac_i, .ip_hdr_i, .route_hit_i, .route_port_i, .arp_hit_i,
    .arp_mac_i, .tbl_we_i, .tbl_idx_i, .tbl_wr_addr_i, .tbl_wr_en_i,
    .tbl_rd_addr_o(rd_addr_d), .tbl_rd_en_o(rd_en_d), .out_valid_o(val_d),
    .out_fwd_o(fwd_d), .out_ports_o(ports_d), .out_dmac_o(dmac_d),
    .out_ttl_o(ttl_d), .out_csum_o(csum_d));

  fp_hdr_proc #(.PUNT_TO_CPU(1'b1)) i_fp_hdr_proc_cpu (
    .clk_i, .rst_ni, .hdr_valid_i, .from_cpu_i, .ingress_i, .eth_type_i,
    .eth_dmac_i, .ip_hdr_i, .route_hit_i, .route_port_i, .arp_hit_i,
    .arp_mac_i, .tbl_we_i, .tbl_idx_i, .tbl_wr_addr_i, .tbl_wr_en_i,
    .tbl_rd_addr_o(rd_addr_c), .tbl_rd_en_o(rd_en_c), .out_valid_o(val_c),
    .out_fwd_o(fwd_c), .out_ports_o(ports_c), .out_dmac_o(dmac_c),
    .out_ttl_o(ttl_c), .out_csum_o(csum_c));

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] calc_csum(logic [159:0] h);
    logic [19:0] a = '0;
    logic [16:0] f;
    for (int i = 0; i < 10; i++) if (i != 4) a += {4'b0, h[16*i +: 16]};
    f = {1'b0, a[15:0]} + {13'b0, a[19:16]};
    f = {1'b0, f[15:0]} + {16'b0, f[16]};
    return ~f[15:0];
  endfunction

  function automatic logic [159:0] mk_hdr(logic [3:0] ver, logic [3:0] ihl,
                                          logic [7:0] ttl, logic [31:0] dst);
    logic [159:0] h;
    h = {ver, ihl, 8'h00, 16'd84, 16'h1c46, 16'h4000, ttl, 8'd17, 16'h0000,
         32'hc0a8_0102, dst};
    h[79:64] = calc_csum(h);
    return h;
  endfunction

  // drive one packet, sample after the register stage, then check idle
  task automatic send(string req, logic [1:0] ing, logic cpu, logic [15:0] et,
                      logic [159:0] h, logic rh, logic [1:0] rp, logic ah,
                      logic exp_fwd);
    logic [159:0] nh;
    logic [VEC_W-1:0] ed, ec;
    @(negedge clk_i);
    hdr_valid_i = 1; from_cpu_i = cpu; ingress_i = ing; eth_type_i = et;
    eth_dmac_i = 48'h0200_0000_00aa; ip_hdr_i = h; route_hit_i = rh;
    route_port_i = rp; arp_hit_i = ah; arp_mac_i = 48'h0211_2233_4455;
    @(negedge clk_i);
    hdr_valid_i = 0;
    nh = h;
    if (cpu) begin
      ed = VEC_W'(1) << (2 * ing); ec = ed;
    end else if (exp_fwd) begin
      ed = VEC_W'(1) << (2 * rp); ec = ed;
      nh[95:88] = h[95:88] - 8'd1;
      nh[79:64] = calc_csum(nh);
    end else begin
      ed = '0; ec = VEC_W'(1) << (2 * ing + 1);
    end
    chk(req, "valid", 64'(val_d), 64'd1);
    chk(req, "fwd", 64'(fwd_d), 64'(exp_fwd && !cpu));
    chk(req, "ports drop-mode R8", 64'(ports_d), 64'(ed));
    chk(req, "ports cpu-mode R9", 64'(ports_c), 64'(ec));
    chk(req, "ttl R2", 64'(ttl_d), 64'(nh[95:88]));
    chk(req, "csum R3", 64'(csum_d), 64'(nh[79:64]));
    chk(req, "dmac R7", 64'(dmac_d),
        (exp_fwd && !cpu) ? 64'h0211_2233_4455 : 64'h0200_0000_00aa);
    chk(req, "cpu-mode ttl R10", 64'(ttl_c), 64'(nh[95:88]));
    chk(req, "cpu-mode csum R10", 64'(csum_c), 64'(nh[79:64]));
    @(negedge clk_i);
    chk("R12", "idle valid", 64'(val_d), 64'd0);
    chk("R12", "idle ports", 64'(ports_c | ports_d), 64'd0);
  endtask

  task automatic tbl_write(logic [1:0] idx, logic [31:0] a, logic en);
    @(negedge clk_i);
    tbl_we_i = 1; tbl_idx_i = idx; tbl_wr_addr_i = a; tbl_wr_en_i = en;
    @(negedge clk_i);
    tbl_we_i = 0;
    chk("R4", "readback addr", 64'(rd_addr_d), 64'(a));
    chk("R4", "readback en", 64'(rd_en_d), 64'(en));
  endtask

  task automatic t_reset();
    chk("R12", "reset valid", 64'(val_d | val_c), 64'd0);
    chk("R12", "reset ports", 64'(ports_d | ports_c), 64'd0);
    for (int i = 0; i < 4; i++) begin
      tbl_idx_i = 2'(i); #1;
      chk("R4", "reset en", 64'(rd_en_d), 64'd0);
    end
  endtask

  task automatic t_forward();
    send("R1 R7 basic", 2'd0, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a01_0203), 1, 2'd2, 1, 1);
    send("R7 port3", 2'd1, 0, 16'h0800, mk_hdr(4, 5, 8'd200, 32'hac10_0001), 1, 2'd3, 1, 1);
    send("R2 ttl2 edge", 2'd3, 0, 16'h0800, mk_hdr(4, 5, 8'd2, 32'h0a00_0009), 1, 2'd0, 1, 1);
    send("R3 ttl255", 2'd2, 0, 16'h0800, mk_hdr(4, 5, 8'd255, 32'hffff_0000), 1, 2'd1, 1, 1);
  endtask

  task automatic t_expired();
    send("R2 ttl1", 2'd1, 0, 16'h0800, mk_hdr(4, 5, 8'd1, 32'h0a01_0203), 1, 2'd2, 1, 0);
    send("R2 ttl0", 2'd2, 0, 16'h0800, mk_hdr(4, 5, 8'd0, 32'h0a01_0203), 1, 2'd0, 1, 0);
  endtask

  task automatic t_bad_fields();
    logic [159:0] h;
    send("R1 arp etype", 2'd0, 0, 16'h0806, mk_hdr(4, 5, 8'd64, 32'h0a01_0203), 1, 2'd1, 1, 0);
    send("R1 version6", 2'd1, 0, 16'h0800, mk_hdr(6, 5, 8'd64, 32'h0a01_0203), 1, 2'd2, 1, 0);
    send("R1 options", 2'd2, 0, 16'h0800, mk_hdr(4, 6, 8'd64, 32'h0a01_0203), 1, 2'd3, 1, 0);
    h = mk_hdr(4, 5, 8'd64, 32'h0a01_0203);
    h[64] = ~h[64];
    send("R1 bad csum", 2'd3, 0, 16'h0800, h, 1, 2'd0, 1, 0);
  endtask

  task automatic t_misses();
    send("R6 route miss", 2'd0, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a01_0203), 0, 2'd2, 1, 0);
    send("R6 arp miss", 2'd3, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a01_0203), 1, 2'd2, 0, 0);
  endtask

  task automatic t_local();
    tbl_write(2'd2, 32'h0a00_0001, 1);
    tbl_write(2'd0, 32'h0a00_0002, 0);
    send("R5 local hit", 2'd1, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a00_0001), 1, 2'd2, 1, 0);
    send("R5 disabled entry", 2'd1, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a00_0002), 1, 2'd2, 1, 1);
    tbl_write(2'd2, 32'h0a00_0001, 0);
    send("R5 after disable", 2'd1, 0, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a00_0001), 1, 2'd2, 1, 1);
    tbl_idx_i = 2'd0; #1;
    chk("R4", "other entry kept", 64'(rd_addr_d), 64'h0a00_0002);
  endtask

  task automatic t_from_cpu();
    send("R11 cpu ttl0", 2'd2, 1, 16'h0800, mk_hdr(4, 5, 8'd0, 32'h0a01_0203), 0, 2'd0, 0, 0);
    send("R11 cpu good", 2'd1, 1, 16'h0800, mk_hdr(4, 5, 8'd64, 32'h0a01_0203), 1, 2'd3, 1, 0);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 t_reset();
    #20 rst_ni = 1;
    t_forward();
    t_expired();
    t_bad_fields();
    t_misses();
    t_local();
    t_from_cpu();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule